// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block converts a pair of parallel audio samples (left and right) into a single serial data line and generates the matching word clock. It runs directly on an externally supplied bit clock and supports four framing conventions: I2S, left-justified, right-justified and DSP with a one-bit frame-sync pulse. Every frame is 64 bit clocks long.

The word length (16 to 24 bits) and the format are read once per frame, together with the two samples, at the frame boundary. Each sample input is 24 bits wide. The transmitted word is its most significant bits, and it is sent MSB first. Every bit position outside the active word is driven low. Both outputs are registered on the falling edge of the bit clock. A receiver that samples on the rising edge therefore sees stable data.

Top module: `stereo_ser_tx`

## Requirements
- R1: While rst_ni is low, ws_o and sd_o are low, whatever the bit clock does. Bit position 0 of the first frame appears on the first falling bit-clock edge after reset is released.
- R2: A frame is 64 bit clocks long and positions run 0 to 63. Both outputs change only on the falling edge of bclk_i, and every falling edge advances the position by one.
- R3: In I2S mode (fmt code 2'b00), ws_o is low for positions 0..31 (left) and high for 32..63 (right). The MSB of each channel is at position 1 of its half and is followed by the rest of the word.
- R4: In left-justified mode (fmt code 2'b01), ws_o is high for positions 0..31 (left) and low for 32..63 (right). The MSB of each channel is at position 0 of its half.
- R5: In right-justified mode (fmt code 2'b10), ws_o is high for the left half and low for the right half. The word of W bits occupies half-positions 32-W..31, so its LSB is the last bit of the half.
- R6: In DSP mode (fmt code 2'b11), ws_o is high only at position 0. Left bits occupy positions 1..W and right bits occupy positions W+1..2W, with no channel marking.
- R7: Every bit position outside the active word of the current format is driven low on sd_o.
- R8: The word sent for a channel is bits 23 down to 24-W of that channel's sample input, in that order.
- R9: The word length W is wlen_i clamped to 16..24. A value below 16 gives 16, and a value above 24 gives 24.
- R10: Format, word length and both samples are captured only at frame start, position 0. Changes at any other time have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock; outputs update on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Format code: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| wlen_i | input | 5 | Requested word length in bits (clamped to 16..24) |
| left_i | input | 24 | Left sample, MSB in bit 23 |
| right_i | input | 24 | Right sample, MSB in bit 23 |
| ws_o | output | 1 | Word clock or frame-sync pulse |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
A wrong position count shows within one bit clock. The word-clock edge or the DSP pulse lands on the wrong position, or the data appears shifted by one slot against the word clock. A wrong captured format, length or sample is visible on the very first bit of the affected word. A capture that happens mid-frame shows at the next disturbed bit, because the data then drifts from the values latched at frame start. Comparing every position of every frame against a computed stream therefore localises a fault to a single bit period.

// File: rtl/sst_pkg.sv
package sst_pkg;

    // Serial framing conventions; the code values are part of the port contract.
    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

endpackage

// File: rtl/sst_bit_timer.sv
module sst_bit_timer #(
    parameter int unsigned POS_W = 6
) (
    input  logic             bclk_i,
    input  logic             rst_ni,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic             start_nxt_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.pos = tmr_q.pos + POS_W'(1);
    end

    // Reset parks the counter on the last position so the first edge opens a frame.
    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q.pos <= '1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pos_o       = tmr_q.pos;
    assign pos_nxt_o   = tmr_d.pos;
    assign start_nxt_o = (tmr_d.pos == '0);

endmodule

// File: rtl/sst_frame_cfg.sv
module sst_frame_cfg
    import sst_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned WLEN_W   = 5,
    parameter int unsigned WLEN_MIN = 16,
    parameter int unsigned WLEN_MAX = 24
) (
    input  logic                bclk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  fmt_e                fmt_i,
    input  logic [WLEN_W-1:0]   wlen_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output fmt_e                fmt_nxt_o,
    output logic [WLEN_W-1:0]   wlen_nxt_o,
    output logic [SAMPLE_W-1:0] left_nxt_o,
    output logic [SAMPLE_W-1:0] right_nxt_o,
    output fmt_e                fmt_o,
    output logic [WLEN_W-1:0]   wlen_o
);

    typedef struct packed {
        fmt_e                fmt;
        logic [WLEN_W-1:0]   wlen;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [WLEN_W-1:0] wlen_clamped;

    always_comb begin
        if (wlen_i < WLEN_W'(WLEN_MIN)) begin
            wlen_clamped = WLEN_W'(WLEN_MIN);
        end else if (wlen_i > WLEN_W'(WLEN_MAX)) begin
            wlen_clamped = WLEN_W'(WLEN_MAX);
        end else begin
            wlen_clamped = wlen_i;
        end

        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.fmt   = fmt_i;
            cfg_d.wlen  = wlen_clamped;
            cfg_d.left  = left_i;
            cfg_d.right = right_i;
        end
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.fmt   <= FMT_I2S;
            cfg_q.wlen  <= WLEN_W'(WLEN_MAX);
            cfg_q.left  <= '0;
            cfg_q.right <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fmt_nxt_o   = cfg_d.fmt;
    assign wlen_nxt_o  = cfg_d.wlen;
    assign left_nxt_o  = cfg_d.left;
    assign right_nxt_o = cfg_d.right;
    assign fmt_o       = cfg_q.fmt;
    assign wlen_o      = cfg_q.wlen;

endmodule

// File: rtl/sst_slot_map.sv
module sst_slot_map
    import sst_pkg::*;
#(
    parameter int unsigned POS_W     = 6,
    parameter int unsigned WLEN_W    = 5,
    parameter int unsigned HALF_BITS = 32
) (
    input  logic [POS_W-1:0]  pos_i,
    input  fmt_e              fmt_i,
    input  logic [WLEN_W-1:0] wlen_i,
    output logic              ws_o,
    output logic              active_o,
    output logic              chan_o,
    output logic [POS_W-1:0]  bit_o
);

    logic             half;
    logic [POS_W-1:0] idx;
    logic [POS_W-1:0] wl;
    logic [POS_W-1:0] wl2;
    logic [POS_W-1:0] lead;

    always_comb begin
        half     = pos_i[POS_W-1];
        idx      = {1'b0, pos_i[POS_W-2:0]};
        wl       = POS_W'(wlen_i);
        wl2      = wl + wl;
        lead     = POS_W'(HALF_BITS) - wl;
        ws_o     = 1'b0;
        active_o = 1'b0;
        chan_o   = half;
        bit_o    = '0;

        unique case (fmt_i)
            FMT_I2S: begin
                // Word clock low on the left half, data delayed one slot.
                ws_o = half;
                if (idx >= POS_W'(1) && idx <= wl) begin
                    active_o = 1'b1;
                    bit_o    = idx - POS_W'(1);
                end
            end
            FMT_LJ: begin
                ws_o = ~half;
                if (idx < wl) begin
                    active_o = 1'b1;
                    bit_o    = idx;
                end
            end
            FMT_RJ: begin
                ws_o = ~half;
                if (idx >= lead) begin
                    active_o = 1'b1;
                    bit_o    = idx - lead;
                end
            end
            FMT_DSP: begin
                // Single-slot sync, then left and right words back to back.
                ws_o = (pos_i == '0);
                if (pos_i >= POS_W'(1) && pos_i <= wl) begin
                    active_o = 1'b1;
                    chan_o   = 1'b0;
                    bit_o    = pos_i - POS_W'(1);
                end else if (pos_i > wl && pos_i <= wl2) begin
                    active_o = 1'b1;
                    chan_o   = 1'b1;
                    bit_o    = pos_i - POS_W'(1) - wl;
                end
            end
            default: begin
                ws_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
    import sst_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 24,
    parameter int unsigned WLEN_W    = 5,
    parameter int unsigned WLEN_MIN  = 16,
    parameter int unsigned WLEN_MAX  = 24,
    parameter int unsigned HALF_BITS = 32
) (
    input  logic                bclk_i,
    input  logic                rst_ni,
    input  logic [1:0]          fmt_i,
    input  logic [WLEN_W-1:0]   wlen_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                ws_o,
    output logic                sd_o
);

    localparam int unsigned FRAME_BITS = 2 * HALF_BITS;
    localparam int unsigned POS_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic ws;
        logic sd;
    } out_t;

    logic [POS_W-1:0]    pos_q;
    logic [POS_W-1:0]    pos_nxt;
    logic                start_nxt;
    fmt_e                fmt_nxt;
    fmt_e                cur_fmt;
    logic [WLEN_W-1:0]   wlen_nxt;
    logic [WLEN_W-1:0]   cur_wlen;
    logic [SAMPLE_W-1:0] left_nxt;
    logic [SAMPLE_W-1:0] right_nxt;
    logic                slot_ws;
    logic                slot_active;
    logic                slot_chan;
    logic [POS_W-1:0]    slot_bit;
    logic [SAMPLE_W-1:0] word_sel;
    logic [SAMPLE_W-1:0] word_shift;
    out_t                out_d, out_q;

    sst_bit_timer #(
        .POS_W (POS_W)
    ) u_timer (
        .bclk_i      (bclk_i),
        .rst_ni      (rst_ni),
        .pos_o       (pos_q),
        .pos_nxt_o   (pos_nxt),
        .start_nxt_o (start_nxt)
    );

    sst_frame_cfg #(
        .SAMPLE_W (SAMPLE_W),
        .WLEN_W   (WLEN_W),
        .WLEN_MIN (WLEN_MIN),
        .WLEN_MAX (WLEN_MAX)
    ) u_cfg (
        .bclk_i      (bclk_i),
        .rst_ni      (rst_ni),
        .load_i      (start_nxt),
        .fmt_i       (fmt_e'(fmt_i)),
        .wlen_i      (wlen_i),
        .left_i      (left_i),
        .right_i     (right_i),
        .fmt_nxt_o   (fmt_nxt),
        .wlen_nxt_o  (wlen_nxt),
        .left_nxt_o  (left_nxt),
        .right_nxt_o (right_nxt),
        .fmt_o       (cur_fmt),
        .wlen_o      (cur_wlen)
    );

    // Decode the position about to be driven, using the configuration it will see.
    sst_slot_map #(
        .POS_W     (POS_W),
        .WLEN_W    (WLEN_W),
        .HALF_BITS (HALF_BITS)
    ) u_map (
        .pos_i    (pos_nxt),
        .fmt_i    (fmt_nxt),
        .wlen_i   (wlen_nxt),
        .ws_o     (slot_ws),
        .active_o (slot_active),
        .chan_o   (slot_chan),
        .bit_o    (slot_bit)
    );

    always_comb begin
        word_sel   = slot_chan ? right_nxt : left_nxt;
        word_shift = word_sel << slot_bit;
        out_d.ws   = slot_ws;
        out_d.sd   = slot_active & word_shift[SAMPLE_W-1];
    end

    always_ff @(negedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ws_o = out_q.ws;
    assign sd_o = out_q.sd;

endmodule

// File: rtl/sst_chk.sv
module sst_chk
    import sst_pkg::*;
#(
    parameter int unsigned POS_W     = 6,
    parameter int unsigned WLEN_W    = 5,
    parameter int unsigned WLEN_MIN  = 16,
    parameter int unsigned WLEN_MAX  = 24,
    parameter int unsigned HALF_BITS = 32
) (
    input logic              bclk,
    input logic              rst_n,
    input logic              ws,
    input logic              sd,
    input logic [POS_W-1:0]  pos,
    input fmt_e              fmt,
    input logic [WLEN_W-1:0] wlen
);

    logic [POS_W-1:0] wl;
    logic [POS_W-1:0] wl2;
    logic [POS_W-1:0] idx;
    logic [POS_W-1:0] lead;
    logic             mid_half;

    assign wl       = POS_W'(wlen);
    assign wl2      = wl + wl;
    assign idx      = {1'b0, pos[POS_W-2:0]};
    assign lead     = POS_W'(HALF_BITS) - wl;
    assign mid_half = (pos != '0) && (pos != POS_W'(HALF_BITS));

    // R2
    frame_wrap_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (pos == '1) |=> (pos == '0));

    // R10
    cfg_hold_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (pos != '0) |-> ($stable(fmt) && $stable(wlen)));

    // R9
    wlen_range_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (wlen >= WLEN_W'(WLEN_MIN)) && (wlen <= WLEN_W'(WLEN_MAX)));

    // R4
    ws_level_hold_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt != FMT_DSP && mid_half) |-> $stable(ws));

    // R3
    i2s_gap_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt == FMT_I2S && idx == '0) |-> !sd);

    // R7
    lj_tail_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt == FMT_LJ && idx >= wl) |-> !sd);

    // R5
    rj_lead_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt == FMT_RJ && idx < lead) |-> !sd);

    // R6
    dsp_pulse_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt == FMT_DSP && ws) |=> !ws);

    // R6
    dsp_tail_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (fmt == FMT_DSP && pos > wl2) |-> !sd);

endmodule

bind stereo_ser_tx sst_chk #(
    .POS_W     (POS_W),
    .WLEN_W    (WLEN_W),
    .WLEN_MIN  (WLEN_MIN),
    .WLEN_MAX  (WLEN_MAX),
    .HALF_BITS (HALF_BITS)
) u_sst_chk (
    .bclk  (bclk_i),
    .rst_n (rst_ni),
    .ws    (ws_o),
    .sd    (sd_o),
    .pos   (pos_q),
    .fmt   (cur_fmt),
    .wlen  (cur_wlen)
);

// File: tb/stereo_ser_tx_bench.sv
`timescale 1ns/1ps
module stereo_ser_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [4:0]  wlen = 5'd24;
    logic [23:0] left = '0;
    logic [23:0] right = '0;
    logic        ws;
    logic        sd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    stereo_ser_tx u_stereo_ser_tx (
        .bclk_i  (clk),
        .rst_ni  (rst_n),
        .fmt_i   (fmt),
        .wlen_i  (wlen),
        .left_i  (left),
        .right_i (right),
        .ws_o    (ws),
        .sd_o    (sd)
    );

    task automatic check_bit(input string req, input string what, input int p,
                             input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s pos=%0d actual=%0b expected=%0b", req, what, p, act, exp);
        end
    endtask

    function automatic int clamp_len(input int w);
        if (w < 16) return 16;
        if (w > 24) return 24;
        return w;
    endfunction

    // Expected outputs per position, from the format rules.
    task automatic model(input int m, input int w, input logic [23:0] l, input logic [23:0] r,
                         input int p, output logic ews, output logic esd);
        int half = p / 32;
        int idx  = p % 32;
        int k    = -1;
        logic [23:0] s = (half == 1) ? r : l;
        case (m)
            0: begin ews = (half == 1); k = idx - 1; end
            1: begin ews = (half == 0); k = idx; end
            2: begin ews = (half == 0); k = idx - (32 - w); end
            default: begin
                ews = (p == 0);
                if (p >= 1 && p <= w) begin s = l; k = p - 1; end
                else if (p > w && p <= 2 * w) begin s = r; k = p - 1 - w; end
                else k = -1;
            end
        endcase
        esd = (k >= 0 && k < w) ? s[23 - k] : 1'b0;
    endtask

    // Called just after a rising edge while position 63 (or reset park) is shown.
    task automatic run_frame(input int m, input int w, input logic [23:0] l,
                             input logic [23:0] r, input string req, input bit disturb);
        int cw = clamp_len(w);
        logic ews, esd;
        fmt   = m[1:0];
        wlen  = w[4:0];
        left  = l;
        right = r;
        for (int p = 0; p < 64; p++) begin
            @(posedge clk);
            #1;
            model(m, cw, l, r, p, ews, esd);
            check_bit(req, "ws", p, ws, ews);
            check_bit(req, "sd", p, sd, esd);
            if (disturb && p == 10) begin
                fmt   = ~m[1:0];
                wlen  = 5'd17;
                left  = ~l;
                right = ~r;
            end
        end
    endtask

    task automatic test_reset;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1", "ws in reset", -1, ws, 1'b0);
        check_bit("R1", "sd in reset", -1, sd, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic test_left_justified;
        run_frame(1, 24, 24'hA5C3F1, 24'h3C5A96, "R1 R2 R4 R8", 1'b0);
        run_frame(1, 18, 24'hFFFFFF, 24'h800001, "R4 R7 R8", 1'b0);
    endtask

    task automatic test_i2s;
        run_frame(0, 24, 24'h9E3779, 24'h61C886, "R3 R8", 1'b0);
        run_frame(0, 20, 24'hFFFFFF, 24'hFFFFFF, "R3 R7", 1'b0);
    endtask

    task automatic test_right_justified;
        run_frame(2, 16, 24'hFFFFFF, 24'hC0FFEE, "R5 R7 R8", 1'b0);
        run_frame(2, 24, 24'h13579B, 24'hFDB975, "R5 R8", 1'b0);
    endtask

    task automatic test_dsp;
        run_frame(3, 24, 24'hFFFFFF, 24'hA0A0A5, "R6 R8", 1'b0);
        run_frame(3, 19, 24'h5BD1E9, 24'hFFFFFF, "R6 R7", 1'b0);
    endtask

    task automatic test_clamp;
        run_frame(1, 8, 24'hFFFFFF, 24'hFFFFFF, "R9 low", 1'b0);
        run_frame(2, 30, 24'hFFFFFF, 24'h7E1234, "R9 high", 1'b0);
    endtask

    task automatic test_midframe;
        run_frame(1, 24, 24'hCAFE55, 24'h0F1E2D, "R10", 1'b1);
        run_frame(3, 16, 24'hFFFFFF, 24'hFFFFFF, "R10", 1'b1);
    endtask

    task automatic test_async_reset;
        fmt  = 2'b01;
        wlen = 5'd24;
        left = 24'hFFFFFF;
        repeat (5) @(posedge clk);
        #1;
        check_bit("R1", "ws before reset", -1, ws, 1'b1);
        rst_n = 1'b0;
        #1;
        check_bit("R1", "ws async reset", -1, ws, 1'b0);
        check_bit("R1", "sd async reset", -1, sd, 1'b0);
        repeat (2) @(posedge clk);
        #1;
        check_bit("R1", "ws held reset", -1, ws, 1'b0);
        rst_n = 1'b1;
        run_frame(0, 16, 24'hB4C3D2, 24'h1A2B3C, "R1 R3", 1'b0);
    endtask

    initial begin
        test_reset();
        test_left_justified();
        test_i2s();
        test_right_justified();
        test_dsp();
        test_clamp();
        test_midframe();
        test_async_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule